// File: doc/BRIEF.md
# Checkpointed Register Pointer File

This block keeps several physical copies of every architectural register, one per speculative checkpoint, together with a small pointer per register. The pointer names the copy that currently holds the committed value. Taking a checkpoint, committing one, or abandoning one never copies register contents. A commit only moves the pointers of the registers that the checkpoint wrote. Abandoning a checkpoint only drops its bookkeeping bits.

One write port serves three kinds of writer. A non-speculative writer updates the copy the pointer names. A leading (ahead) speculative writer updates the copy of its checkpoint. A trailing (behind) speculative writer fills in results that were left not-available (NA). Each copy of each register carries a written bit and an NA bit. A merge strobe folds the trailing thread's NA vector into a checkpoint's NA bits. A registered read port returns the committed value of any register.

Top module: `ckpt_reg_ptr_file`

## Requirements
- R1: After reset every copy of every register holds zero, every pointer names copy 0, all written and NA bits are clear, and `rd_data` is zero.
- R2: A write with `wr_spec`=0 stores `wr_data` into the copy named by the register's pointer. It changes no NA bit and no written bit.
- R3: A write with `wr_spec`=1 and `wr_behind`=0 targets copy `wr_ckpt`. It sets that copy's written bit and loads its NA bit with `wr_na`. It stores `wr_data` only when `wr_na`=0. NA bit of copy c, register j is `spec_na[c*NUM_REGS+j]`.
- R4: A write with `wr_spec`=1 and `wr_behind`=1 takes effect only when the target NA bit is set and `wr_na`=0. It then stores the data and sets the written bit, and it leaves the NA bit set. In any other case it has no effect.
- R5: Commit of checkpoint c moves to c the pointer of every register whose written bit in c is set. All other pointers are unchanged. The written and NA bits of c are then cleared.
- R6: Fail of checkpoint c clears the written and NA bits of c and leaves every pointer unchanged.
- R7: Merge of checkpoint c replaces each NA bit of c by its AND with the matching bit of `merge_na`. The merge is applied after a same-cycle write.
- R8: `rd_data` shows, one cycle after `rd_reg` is presented, the copy named by that register's pointer, as it stood before that clock edge.
- R9: A speculative write and a commit of the same checkpoint in one cycle count as write-first: the written register's pointer moves. A fail of the committing checkpoint in the same cycle wins: no pointer moves and the bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_spec | input | 1 | Write belongs to a speculative phase |
| wr_behind | input | 1 | Write comes from the trailing thread |
| wr_ckpt | input | CW | Checkpoint of a speculative write |
| wr_reg | input | RW | Destination register |
| wr_na | input | 1 | Writer is deferrable (result not available) |
| wr_data | input | DATA_W | Write value |
| commit_en | input | 1 | Commit strobe |
| commit_ckpt | input | CW | Checkpoint being committed |
| fail_en | input | 1 | Fail strobe |
| fail_ckpt | input | CW | Checkpoint being abandoned |
| merge_en | input | 1 | Merge strobe |
| merge_ckpt | input | CW | Checkpoint whose NA bits are merged |
| merge_na | input | NUM_REGS | Trailing-thread NA vector |
| rd_reg | input | RW | Register to read |
| rd_data | output | DATA_W | Committed value, one cycle later |
| spec_na | output | NUM_CKPT*NUM_REGS | NA bits, copy-major |

## Verification
The sensitive overlap is a commit that lands in the same cycle as a speculative write to the committing checkpoint, or as a fail of that checkpoint. The bench provokes both in directed steps and again at random. It judges the outcome through `rd_data` on the following reads and through `spec_na`, against a bench model that applies write, merge, commit and fail in the required order.

// File: rtl/ckpf_pkg.sv
package ckpf_pkg;

   // kind of access presented on the write port
   typedef enum logic [1:0] {
      WK_NONE   = 2'd0,
      WK_ARCH   = 2'd1,
      WK_AHEAD  = 2'd2,
      WK_BEHIND = 2'd3
   } wr_kind_e;

   function automatic int idx_w(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/ckpf_bank.sv
module ckpf_bank #(
   parameter int NUM_REGS = 16,
   parameter int DATA_W   = 32,
   parameter int RW       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [RW-1:0]     wr_reg,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [RW-1:0]     rd_reg,
   output logic [DATA_W-1:0] rd_word
);

   logic [DATA_W-1:0] mem_q [NUM_REGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
      end else if (we) begin
         mem_q[wr_reg] <= wr_data;
      end
   end

   assign rd_word = mem_q[rd_reg];

endmodule

// File: rtl/ckpf_flags.sv
module ckpf_flags #(
   parameter int NUM_REGS = 16,
   parameter int NUM_CKPT = 2,
   parameter int RW       = 4,
   parameter int CW       = 1
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               mark_en,
   input  logic                               na_load,
   input  logic                               na_val,
   input  logic [CW-1:0]                      wr_ckpt,
   input  logic [RW-1:0]                      wr_reg,
   input  logic                               commit_en,
   input  logic [CW-1:0]                      commit_ckpt,
   input  logic                               fail_en,
   input  logic [CW-1:0]                      fail_ckpt,
   input  logic                               merge_en,
   input  logic [CW-1:0]                      merge_ckpt,
   input  logic [NUM_REGS-1:0]                merge_na,
   output logic [NUM_CKPT-1:0][NUM_REGS-1:0]  na_q,
   output logic [NUM_REGS-1:0]                commit_mask
);

   logic [NUM_CKPT-1:0][NUM_REGS-1:0] wrb_q;
   logic [NUM_CKPT-1:0][NUM_REGS-1:0] wrb_seen;
   logic [NUM_CKPT-1:0][NUM_REGS-1:0] wrb_d;
   logic [NUM_CKPT-1:0][NUM_REGS-1:0] na_d;

   always_comb begin
      for (int c = 0; c < NUM_CKPT; c++) begin
         for (int j = 0; j < NUM_REGS; j++) begin
            logic hit;
            logic nn;
            hit = (wr_ckpt == CW'(c)) && (wr_reg == RW'(j));
            wrb_seen[c][j] = wrb_q[c][j] | (mark_en & hit);
            nn = (na_load && hit) ? na_val : na_q[c][j];
            if (merge_en && merge_ckpt == CW'(c)) nn = nn & merge_na[j];
            if ((commit_en && commit_ckpt == CW'(c)) || (fail_en && fail_ckpt == CW'(c))) begin
               na_d[c][j]  = 1'b0;
               wrb_d[c][j] = 1'b0;
            end else begin
               na_d[c][j]  = nn;
               wrb_d[c][j] = wrb_seen[c][j];
            end
         end
      end
   end

   // write-first view of the committing checkpoint's written bits
   assign commit_mask = wrb_seen[commit_ckpt];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wrb_q <= '0;
         na_q  <= '0;
      end else begin
         wrb_q <= wrb_d;
         na_q  <= na_d;
      end
   end

   AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      commit_en |=> (wrb_q[$past(commit_ckpt)] == '0) && (na_q[$past(commit_ckpt)] == '0)); // R5
   AST_FAIL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      fail_en |=> (wrb_q[$past(fail_ckpt)] == '0) && (na_q[$past(fail_ckpt)] == '0)); // R6
   AST_MERGE_AND: assert property (@(posedge clk) disable iff (!rst_n)
      (merge_en && !(commit_en && commit_ckpt == merge_ckpt) && !(fail_en && fail_ckpt == merge_ckpt))
      |=> ((na_q[$past(merge_ckpt)] & ~$past(merge_na)) == '0)); // R7

endmodule

// File: rtl/ckpf_ptr.sv
module ckpf_ptr #(
   parameter int NUM_REGS = 16,
   parameter int CW       = 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          commit_en,
   input  logic                          commit_kill,
   input  logic [CW-1:0]                 commit_ckpt,
   input  logic [NUM_REGS-1:0]           commit_mask,
   output logic [NUM_REGS-1:0][CW-1:0]   ptr_q
);

   genvar j;
   generate
      for (j = 0; j < NUM_REGS; j++) begin : g_ptr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ptr_q[j] <= '0;
            else if (commit_en && !commit_kill && commit_mask[j]) ptr_q[j] <= commit_ckpt;
         end
      end
   endgenerate

   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_en |=> $stable(ptr_q)); // R6
   AST_PTR_KILLED: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_en && commit_kill) |=> $stable(ptr_q)); // R9

endmodule

// File: rtl/ckpt_reg_ptr_file.sv
module ckpt_reg_ptr_file
   import ckpf_pkg::*;
#(
   parameter int NUM_REGS = 16,
   parameter int DATA_W   = 32,
   parameter int NUM_CKPT = 2,
   localparam int RW      = idx_w(NUM_REGS),
   localparam int CW      = idx_w(NUM_CKPT),
   localparam int NA_W    = NUM_CKPT * NUM_REGS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_spec,
   input  logic              wr_behind,
   input  logic [CW-1:0]     wr_ckpt,
   input  logic [RW-1:0]     wr_reg,
   input  logic              wr_na,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              commit_en,
   input  logic [CW-1:0]     commit_ckpt,
   input  logic              fail_en,
   input  logic [CW-1:0]     fail_ckpt,
   input  logic              merge_en,
   input  logic [CW-1:0]     merge_ckpt,
   input  logic [NUM_REGS-1:0] merge_na,
   input  logic [RW-1:0]     rd_reg,
   output logic [DATA_W-1:0] rd_data,
   output logic [NA_W-1:0]   spec_na
);

   // elaboration-time parameter checks
   generate
      if (NUM_CKPT < 2) begin : g_bad_ckpt
         $error("NUM_CKPT must be at least 2");
      end
      if ((1 << CW) != NUM_CKPT) begin : g_bad_pow2
         $error("NUM_CKPT must be a power of two");
      end
      if ((1 << RW) != NUM_REGS) begin : g_bad_regs
         $error("NUM_REGS must be a power of two");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be positive");
      end
   endgenerate

   wr_kind_e                          kind;
   logic [NUM_REGS-1:0][CW-1:0]       ptr_q;
   logic [NUM_CKPT-1:0][NUM_REGS-1:0] na_q;
   logic [NUM_REGS-1:0]               commit_mask;
   logic [CW-1:0]                     tgt_ckpt;
   logic                              na_cur;
   logic                              behind_ok;
   logic                              data_we;
   logic                              mark_en;
   logic                              commit_kill;
   logic [DATA_W-1:0]                 bank_rd [NUM_CKPT];
   logic [DATA_W-1:0]                 rd_q;

   always_comb begin
      if (!wr_en)        kind = WK_NONE;
      else if (!wr_spec) kind = WK_ARCH;
      else if (wr_behind) kind = WK_BEHIND;
      else               kind = WK_AHEAD;
   end

   assign na_cur      = na_q[wr_ckpt][wr_reg];
   assign behind_ok   = (kind == WK_BEHIND) && na_cur && !wr_na;
   assign tgt_ckpt    = (kind == WK_ARCH) ? ptr_q[wr_reg] : wr_ckpt;
   assign data_we     = (kind == WK_ARCH) || ((kind == WK_AHEAD) && !wr_na) || behind_ok;
   assign mark_en     = (kind == WK_AHEAD) || behind_ok;
   assign commit_kill = fail_en && (fail_ckpt == commit_ckpt);

   genvar c;
   generate
      for (c = 0; c < NUM_CKPT; c++) begin : g_copy
         ckpf_bank #(
            .NUM_REGS (NUM_REGS),
            .DATA_W   (DATA_W),
            .RW       (RW)
         ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (data_we && (tgt_ckpt == CW'(c))),
            .wr_reg  (wr_reg),
            .wr_data (wr_data),
            .rd_reg  (rd_reg),
            .rd_word (bank_rd[c])
         );
      end
   endgenerate

   ckpf_flags #(
      .NUM_REGS (NUM_REGS),
      .NUM_CKPT (NUM_CKPT),
      .RW       (RW),
      .CW       (CW)
   ) u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .mark_en     (mark_en),
      .na_load     (kind == WK_AHEAD),
      .na_val      (wr_na),
      .wr_ckpt     (wr_ckpt),
      .wr_reg      (wr_reg),
      .commit_en   (commit_en),
      .commit_ckpt (commit_ckpt),
      .fail_en     (fail_en),
      .fail_ckpt   (fail_ckpt),
      .merge_en    (merge_en),
      .merge_ckpt  (merge_ckpt),
      .merge_na    (merge_na),
      .na_q        (na_q),
      .commit_mask (commit_mask)
   );

   ckpf_ptr #(
      .NUM_REGS (NUM_REGS),
      .CW       (CW)
   ) u_ptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit_en   (commit_en),
      .commit_kill (commit_kill),
      .commit_ckpt (commit_ckpt),
      .commit_mask (commit_mask),
      .ptr_q       (ptr_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= '0;
      else        rd_q <= bank_rd[ptr_q[rd_reg]];
   end

   assign rd_data = rd_q;
   assign spec_na = na_q;

   AST_ARCH_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == WK_ARCH && !commit_en && !fail_en && !merge_en) |=> $stable(spec_na)); // R2
   AST_BEHIND_KEEPS_NA: assert property (@(posedge clk) disable iff (!rst_n)
      (behind_ok && !commit_en && !fail_en && !merge_en)
      |=> spec_na[$past(wr_ckpt) * NUM_REGS + int'($past(wr_reg))]); // R4
   AST_BEHIND_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == WK_BEHIND && !na_cur && !commit_en && !fail_en && !merge_en) |=> $stable(spec_na)); // R4

endmodule

// File: tb/ckpt_reg_ptr_file_test.sv
module ckpt_reg_ptr_file_test;

   localparam int CLK_PERIOD = 10;
   localparam int NR = 16;
   localparam int DW = 32;
   localparam int NC = 2;
   localparam int RW = 4;
   localparam int CW = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en, wr_spec, wr_behind, wr_na;
   logic [CW-1:0] wr_ckpt;
   logic [RW-1:0] wr_reg;
   logic [DW-1:0] wr_data;
   logic          commit_en, fail_en, merge_en;
   logic [CW-1:0] commit_ckpt, fail_ckpt, merge_ckpt;
   logic [NR-1:0] merge_na;
   logic [RW-1:0] rd_reg;
   logic [DW-1:0] rd_data;
   logic [NC*NR-1:0] spec_na;

   ckpt_reg_ptr_file #(.NUM_REGS(NR), .DATA_W(DW), .NUM_CKPT(NC)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_spec(wr_spec), .wr_behind(wr_behind),
      .wr_ckpt(wr_ckpt), .wr_reg(wr_reg), .wr_na(wr_na), .wr_data(wr_data),
      .commit_en(commit_en), .commit_ckpt(commit_ckpt), .fail_en(fail_en), .fail_ckpt(fail_ckpt),
      .merge_en(merge_en), .merge_ckpt(merge_ckpt), .merge_na(merge_na),
      .rd_reg(rd_reg), .rd_data(rd_data), .spec_na(spec_na)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // reference model state
   logic [DW-1:0] m_data [NC][NR];
   logic          m_na   [NC][NR];
   logic          m_wr   [NC][NR];
   int            m_ptr  [NR];

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  done     = 1'b0;

   task automatic clr();
      wr_en = 0; wr_spec = 0; wr_behind = 0; wr_na = 0; wr_ckpt = '0; wr_reg = '0; wr_data = '0;
      commit_en = 0; commit_ckpt = '0; fail_en = 0; fail_ckpt = '0;
      merge_en = 0; merge_ckpt = '0; merge_na = '0;
   endtask

   task automatic model_reset();
      for (int c = 0; c < NC; c++)
         for (int j = 0; j < NR; j++) begin
            m_data[c][j] = '0; m_na[c][j] = 1'b0; m_wr[c][j] = 1'b0;
         end
      for (int j = 0; j < NR; j++) m_ptr[j] = 0;
   endtask

   function automatic logic [NC*NR-1:0] exp_na();
      logic [NC*NR-1:0] v;
      for (int c = 0; c < NC; c++)
         for (int j = 0; j < NR; j++) v[c*NR+j] = m_na[c][j];
      return v;
   endfunction

   // one clock edge of the model, following the requirement order
   task automatic model_edge(output logic [DW-1:0] erd);
      int ck, rg, cc;
      logic seen [NC][NR];
      erd = m_data[m_ptr[rd_reg]][rd_reg];
      ck = int'(wr_ckpt); rg = int'(wr_reg);
      for (int c = 0; c < NC; c++)
         for (int j = 0; j < NR; j++) seen[c][j] = m_wr[c][j];
      if (wr_en && !wr_spec) begin
         m_data[m_ptr[rg]][rg] = wr_data;
      end else if (wr_en && !wr_behind) begin
         seen[ck][rg] = 1'b1;
         m_na[ck][rg] = wr_na;
         if (!wr_na) m_data[ck][rg] = wr_data;
      end else if (wr_en && m_na[ck][rg] && !wr_na) begin
         seen[ck][rg] = 1'b1;
         m_data[ck][rg] = wr_data;
      end
      if (merge_en)
         for (int j = 0; j < NR; j++) m_na[int'(merge_ckpt)][j] &= merge_na[j];
      cc = int'(commit_ckpt);
      if (commit_en && !(fail_en && fail_ckpt == commit_ckpt))
         for (int j = 0; j < NR; j++) if (seen[cc][j]) m_ptr[j] = cc;
      for (int c = 0; c < NC; c++)
         for (int j = 0; j < NR; j++) m_wr[c][j] = seen[c][j];
      if (commit_en)
         for (int j = 0; j < NR; j++) begin m_wr[cc][j] = 0; m_na[cc][j] = 0; end
      if (fail_en)
         for (int j = 0; j < NR; j++) begin m_wr[int'(fail_ckpt)][j] = 0; m_na[int'(fail_ckpt)][j] = 0; end
   endtask

   task automatic step(input string tag);
      logic [DW-1:0] erd;
      logic [NC*NR-1:0] ena;
      model_edge(erd);
      ena = exp_na();
      @(posedge clk);
      #1;
      n_checks++;
      if (rd_data !== erd) begin
         n_fails++;
         $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, erd);
      end
      n_checks++;
      if (spec_na !== ena) begin
         n_fails++;
         $display("FAIL %s spec_na actual=%h expected=%h", tag, spec_na, ena);
      end
   endtask

   task automatic read(input int r, input string tag);
      clr(); rd_reg = RW'(r); step(tag);
   endtask

   task automatic wr(input bit spec, input bit behind, input int ck, input int r,
                     input bit na, input logic [DW-1:0] d);
      wr_en = 1; wr_spec = spec; wr_behind = behind; wr_ckpt = CW'(ck);
      wr_reg = RW'(r); wr_na = na; wr_data = d;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      clr(); rd_reg = '0; model_reset();
      repeat (3) @(posedge clk);
      #1;
      n_checks++;
      if (rd_data !== '0 || spec_na !== '0) begin
         n_fails++;
         $display("FAIL R1 reset actual=%h/%h expected=0/0", rd_data, spec_na);
      end
      rst_n = 1'b1;
      read(5, "R1 reset contents");

      // R2: non-speculative writes follow the pointer
      clr(); wr(0, 0, 0, 2, 0, 32'h1111_0002); rd_reg = 4'd2; step("R2 arch write");
      read(2, "R2 arch readback");

      // R3: ahead writes, deferrable and retirable
      clr(); wr(1, 0, 1, 3, 1, 32'hDEAD_0003); step("R3 ahead deferrable");
      clr(); wr(1, 0, 1, 4, 0, 32'h4444_0004); step("R3 ahead retirable");
      clr(); wr(1, 0, 1, 6, 1, 32'h0); step("R3 ahead deferrable second");

      // R4: behind writes, allowed and blocked
      clr(); wr(1, 1, 1, 3, 0, 32'h3333_0003); step("R4 behind allowed");
      clr(); wr(1, 1, 1, 4, 0, 32'hBAD0_0004); step("R4 behind blocked NA clear");
      clr(); wr(1, 1, 1, 6, 1, 32'hBAD0_0006); step("R4 behind redeferred");

      // R7: merge clears only where the behind vector is zero
      clr(); merge_en = 1; merge_ckpt = 1'b1; merge_na = 16'hFFBF; step("R7 merge");

      // R5: commit moves pointers of written registers
      clr(); commit_en = 1; commit_ckpt = 1'b1; step("R5 commit");
      read(3, "R5 read moved reg3");
      read(4, "R5 read moved reg4");
      read(2, "R5 read unmoved reg2");
      clr(); wr(0, 0, 0, 4, 0, 32'h5555_0004); step("R2 arch write after commit");
      read(4, "R2 readback via moved pointer");

      // R6: fail drops bits, pointers stay
      clr(); wr(1, 0, 0, 4, 0, 32'h6666_0004); step("R6 spec write before fail");
      clr(); wr(1, 0, 0, 7, 1, 32'h0); step("R6 deferrable before fail");
      clr(); fail_en = 1; fail_ckpt = 1'b0; step("R6 fail");
      read(4, "R6 pointer unchanged");
      clr(); commit_en = 1; commit_ckpt = 1'b0; step("R6 commit after fail moves nothing");
      read(4, "R6 still old copy");

      // R9: write-first with commit, and fail beating commit
      clr(); wr(1, 0, 0, 9, 0, 32'h9999_0009); commit_en = 1; commit_ckpt = 1'b0; step("R9 write+commit");
      read(9, "R9 write-first pointer moved");
      clr(); wr(1, 0, 1, 9, 0, 32'hAAAA_0009); commit_en = 1; commit_ckpt = 1'b1;
      fail_en = 1; fail_ckpt = 1'b1; step("R9 fail beats commit");
      read(9, "R9 pointer not moved");

      // R8: read latency with a write to the read register in the same cycle
      clr(); wr(0, 0, 0, 9, 0, 32'h8888_0009); rd_reg = 4'd9; step("R8 read sees pre-edge value");
      read(9, "R8 read sees new value");

      // random mix
      for (int it = 0; it < 4000; it++) begin
         clr();
         if ($urandom % 10 < 7) begin
            wr_en = 1;
            wr_spec = ($urandom % 10) < 8;
            wr_behind = ($urandom % 10) < 4;
            wr_na = ($urandom % 10) < 3;
            wr_ckpt = CW'($urandom % NC);
            wr_reg = RW'(($urandom % 2) ? ($urandom % 4) : ($urandom % NR));
            wr_data = $urandom;
         end
         if ($urandom % 12 == 0) begin commit_en = 1; commit_ckpt = CW'($urandom % NC); end
         if ($urandom % 30 == 0) begin fail_en = 1; fail_ckpt = CW'($urandom % NC); end
         if ($urandom % 10 == 0) begin merge_en = 1; merge_ckpt = CW'($urandom % NC); merge_na = NR'($urandom); end
         rd_reg = RW'(($urandom % 2) ? ($urandom % 4) : ($urandom % NR));
         step("random R3 R4 R5 R7 R8 R9");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule